// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is a small bus master that moves a CPU clock onto a new PLL setting without letting any clock leave its safe range. A single start pulse launches a fixed sequence of register accesses towards a clock control unit. First it confirms the peripheral PLL setting and rewrites it only when it is wrong. Next it loads the bus dividers and parks the CPU clock on the crystal reference. It then programs the PLL factors with the enable bit clear and sets the enable bit by read-modify-write. It polls until the PLL reports lock and waits a settle time. Finally it returns the CPU clock to the PLL and waits once more before signalling completion.

Every wait is counted in microseconds. A prescaler divides the system clock into a microsecond tick, and a single down-counter is reloaded at the start of each wait. The same counter times the lock poll against a programmable timeout. If the PLL never locks, the sequence stops with an error and the CPU clock stays on the crystal. Register accesses use a valid/ready handshake with only one access in flight.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy, done, error and bus_valid are all 0.
- R2: The first access reads the peripheral PLL address. If bits 27:0 of the returned word differ from 0x0041811, the next access writes 0x80041811 to that address. Otherwise no write to it is made.
- R3: The next access writes 0x00010203 to the CPU config address: source select at bits 17:16 = 1 (crystal), AXI divider at bits 9:8 = 2 (divide by 3), APB divider at bits 1:0 = 3 (divide by 4). No PLL access comes before it.
- R4: The PLL factor write (0x00001010, bit 31 clear) to the CPU PLL address begins between OSC_WAIT_US*CLK_PER_US and OSC_WAIT_US*CLK_PER_US+8 cycles after the config write.
- R5: The PLL register is then read, and the read value with bit 31 set is written back.
- R6: The PLL register is read repeatedly until a read returns bit 28 = 1. After LOCK_WAIT_US*CLK_PER_US to that value+8 cycles, the config register is read and written back with bits 17:16 replaced by 2 and all other bits kept.
- R7: done pulses for exactly one cycle SWITCH_WAIT_US*CLK_PER_US to that value+8 cycles after the final config write. busy is 0 from that cycle on, and no further access follows.
- R8: If no read returns lock by the first poll read completing at or after lock_timeout_us microseconds, error goes to 1 and busy to 0. This happens within lock_timeout_us*CLK_PER_US+14 cycles of the enable write. No done pulse and no further access follow, so the CPU clock stays on the crystal. The next accepted start clears error.
- R9: A start pulse while busy has no effect on the access sequence and produces no second done.
- R10: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_write, bus_addr and bus_wdata hold their values. A new access starts only after the previous one has completed.
- R11: busy is 1 in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| lock_timeout_us | input | TMO_W | Lock poll timeout in microseconds |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Lock timeout occurred; held until next start |
| bus_valid | output | 1 | Access request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Access complete this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready on reads |

## Verification
A register model in the bench answers each access after a chosen latency and logs the cycle in which the access was presented. Ordering and data checks walk that log. A wait ends N*CLK_PER_US cycles after the timer reload, plus three or four cycles through the bus port and state register plus the responder latency. Each gap check therefore uses a window from N*CLK_PER_US to N*CLK_PER_US+8 rather than a single cycle. busy is sampled on the falling edge after the start pulse. done and error are captured on falling edges by monitors, so each is seen once, and the done and error cycles are bounded in the same way.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PERI_RD, S_PERI_WR, S_CFG_OSC, S_WAIT_OSC, S_PLL_OFF, S_PLL_RD,
    S_PLL_EN, S_POLL, S_WAIT_LOCK, S_CFG_RD, S_CFG_PLL, S_WAIT_SW
  } seq_state_t;

  localparam int SRC_LSB  = 16;
  localparam int AXI_LSB  = 8;
  localparam int APB_LSB  = 0;
  localparam int EN_BIT   = 31;
  localparam int LOCK_BIT = 28;

  localparam logic [1:0]  SRC_OSC = 2'd1;
  localparam logic [1:0]  SRC_PLL = 2'd2;
  localparam logic [31:0] SRC_MASK = 32'h3 << SRC_LSB;
  localparam logic [27:0] PERI_GOOD = 28'h0041811;
  localparam logic [31:0] PERI_WORD = 32'h8004_1811;

  function automatic logic [31:0] cfg_word(logic [1:0] src, int axi_div, int apb_div);
    logic [31:0] w;
    w = 32'(src) << SRC_LSB;
    w = w | ((32'(axi_div - 1) & 32'h3) << AXI_LSB);
    w = w | ((32'(apb_div - 1) & 32'h3) << APB_LSB);
    return w;
  endfunction

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr)        pre <= '0;
    else if (pre == PRE_MAX) pre <= '0;
    else                   pre <= pre + 1'b1;
  end

  assign tick = (pre == PRE_MAX) && !clr;

  generate
    if (CLK_PER_US > 1) begin : g_spaced
      p_tick_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/us_delay.sv
module us_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             zero
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);
endmodule

// File: rtl/seq_bus_port.sv
module seq_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      ack       <= 1'b0;
      rsp_data  <= '0;
    end else begin
      ack <= 1'b0;
      if (bus_valid && bus_ready) begin
        bus_valid <= 1'b0;
        ack       <= 1'b1;
        if (!bus_write) rsp_data <= bus_rdata;
      end else if (req && !bus_valid) begin
        bus_valid <= 1'b1;
        bus_write <= req_write;
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
      end
    end
  end

  p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_wdata)));

  p_single_out_r10: assert property (@(posedge clk) disable iff (rst)
    req |-> (!bus_valid && !ack));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32,
  parameter int CLK_PER_US     = 50,
  parameter int DLY_W          = 16,
  parameter int TMO_W          = 16,
  parameter logic [ADDR_W-1:0] PLL_ADDR  = 12'h000,
  parameter logic [ADDR_W-1:0] PERI_ADDR = 12'h028,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h050,
  parameter logic [31:0] PLL_FACTOR    = 32'h0000_1010,
  parameter int AXI_DIV        = 3,
  parameter int APB_DIV        = 4,
  parameter int OSC_WAIT_US    = 20,
  parameter int LOCK_WAIT_US   = 20,
  parameter int SWITCH_WAIT_US = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TMO_W-1:0]  lock_timeout_us,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [31:0] CFG_OSC_WORD = cfg_word(SRC_OSC, AXI_DIV, APB_DIV);
  localparam logic [31:0] EN_MASK      = 32'h1 << EN_BIT;
  localparam logic [DLY_W-1:0] OSC_LD  = DLY_W'(OSC_WAIT_US);
  localparam logic [DLY_W-1:0] LOCK_LD = DLY_W'(LOCK_WAIT_US);
  localparam logic [DLY_W-1:0] SW_LD   = DLY_W'(SWITCH_WAIT_US);

  seq_state_t state;
  logic              sent;
  logic              req, req_write, ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_data;
  logic              tmr_load, tick, tmr_zero, locked;
  logic [DLY_W-1:0]  tmr_val;
  logic              bus_state;

  seq_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rsp_data(rsp_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clr(tmr_load), .tick(tick)
  );

  us_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(tick), .zero(tmr_zero)
  );

  assign locked = rsp_data[LOCK_BIT];

  always_comb begin
    bus_state = 1'b1;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    case (state)
      S_PERI_RD: req_addr = PERI_ADDR;
      S_PERI_WR: begin req_write = 1'b1; req_addr = PERI_ADDR; req_wdata = DATA_W'(PERI_WORD); end
      S_CFG_OSC: begin req_write = 1'b1; req_addr = CFG_ADDR;  req_wdata = DATA_W'(CFG_OSC_WORD); end
      S_PLL_OFF: begin req_write = 1'b1; req_addr = PLL_ADDR;  req_wdata = DATA_W'(PLL_FACTOR & ~EN_MASK); end
      S_PLL_RD:  req_addr = PLL_ADDR;
      S_PLL_EN:  begin req_write = 1'b1; req_addr = PLL_ADDR;  req_wdata = rsp_data | DATA_W'(EN_MASK); end
      S_POLL:    req_addr = PLL_ADDR;
      S_CFG_RD:  req_addr = CFG_ADDR;
      S_CFG_PLL: begin
        req_write = 1'b1;
        req_addr  = CFG_ADDR;
        req_wdata = (rsp_data & ~DATA_W'(SRC_MASK)) | (DATA_W'(SRC_PLL) << SRC_LSB);
      end
      default:   bus_state = 1'b0;
    endcase
    req = bus_state && !sent;
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (ack) begin
      case (state)
        S_CFG_OSC: begin tmr_load = 1'b1; tmr_val = OSC_LD; end
        S_PLL_EN:  begin tmr_load = 1'b1; tmr_val = DLY_W'(lock_timeout_us); end
        S_POLL:    if (locked) begin tmr_load = 1'b1; tmr_val = LOCK_LD; end
        S_CFG_PLL: begin tmr_load = 1'b1; tmr_val = SW_LD; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      sent  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req)      sent <= 1'b1;
      else if (ack) sent <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy  <= 1'b1;
          error <= 1'b0;
          state <= S_PERI_RD;
        end
        S_PERI_RD: if (ack)
          state <= (rsp_data[27:0] != PERI_GOOD) ? S_PERI_WR : S_CFG_OSC;
        S_PERI_WR:  if (ack) state <= S_CFG_OSC;
        S_CFG_OSC:  if (ack) state <= S_WAIT_OSC;
        S_WAIT_OSC: if (tmr_zero) state <= S_PLL_OFF;
        S_PLL_OFF:  if (ack) state <= S_PLL_RD;
        S_PLL_RD:   if (ack) state <= S_PLL_EN;
        S_PLL_EN:   if (ack) state <= S_POLL;
        S_POLL: if (ack) begin
          if (locked) state <= S_WAIT_LOCK;
          else if (tmr_zero) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            error <= 1'b1;
          end
        end
        S_WAIT_LOCK: if (tmr_zero) state <= S_CFG_RD;
        S_CFG_RD:    if (ack) state <= S_CFG_PLL;
        S_CFG_PLL:   if (ack) state <= S_WAIT_SW;
        S_WAIT_SW: if (tmr_zero) begin
          state <= S_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_valid && !error));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (error && !busy) |-> !bus_valid);

  p_busy_on_start_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
  localparam int P = 4;
  localparam int OSC_N = 20, LOCK_N = 20, SW_N = 1000;
  localparam logic [11:0] A_PLL = 12'h000, A_PERI = 12'h028, A_CFG = 12'h050;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] lock_timeout_us = 16'd500;
  logic busy, done, error, bus_valid, bus_write, bus_ready;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  pll_reprog_seq #(.CLK_PER_US(P)) u_pll_reprog_seq (
    .clk(clk), .rst(rst), .start(start), .lock_timeout_us(lock_timeout_us),
    .busy(busy), .done(done), .error(error), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int lat = 0, lat_cnt = 0;
  int lock_polls = 0, polls_since_en = 0;
  logic [31:0] pll_reg = 0, cfg_reg = 0, peri_reg = 0;
  logic [11:0] log_addr [64];
  logic        log_wr   [64];
  logic [31:0] log_data [64];
  int          log_cyc  [64];
  int log_n = 0;
  int done_cnt = 0, done_cyc = 0, err_cyc = 0;
  logic err_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (error && !err_prev) err_cyc = cyc;
    err_prev = error;
  end

  task automatic do_access();
    logic [31:0] rd;
    rd = 32'h0;
    if (log_n < 64) begin
      log_addr[log_n] = bus_addr;
      log_wr[log_n]   = bus_write;
      log_data[log_n] = bus_write ? bus_wdata : 32'h0;
      log_cyc[log_n]  = cyc;
      log_n++;
    end
    if (bus_write) begin
      if (bus_addr == A_PLL) begin pll_reg = bus_wdata; polls_since_en = 0; end
      else if (bus_addr == A_CFG) cfg_reg = bus_wdata;
      else if (bus_addr == A_PERI) peri_reg = bus_wdata;
    end else begin
      if (bus_addr == A_PLL) begin
        rd = pll_reg;
        if (pll_reg[31]) begin
          if (polls_since_en >= lock_polls) rd[28] = 1'b1;
          polls_since_en++;
        end
      end else if (bus_addr == A_CFG) rd = cfg_reg;
      else if (bus_addr == A_PERI) rd = peri_reg;
    end
    bus_rdata = rd;
  endtask

  initial begin
    bus_ready = 1'b0;
    bus_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (bus_ready) bus_ready = 1'b0;
      else if (bus_valid) begin
        if (lat_cnt < lat) lat_cnt++;
        else begin
          lat_cnt = 0;
          do_access();
          bus_ready = 1'b1;
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int k;
    k = 0;
    while (busy && k < limit) begin @(negedge clk); k++; end
    check(k < limit, "watchdog: sequence did not end", k, limit);
  endtask

  task automatic prep(input logic [31:0] peri, input int polls, input int l);
    peri_reg = peri; pll_reg = 0; cfg_reg = 0;
    lock_polls = polls; lat = l; log_n = 0;
  endtask

  task automatic exp_acc(inout int i, input logic wr, input logic [11:0] a,
                         input logic [31:0] d, input string tag);
    check(i < log_n, {tag, " access present"}, i, log_n);
    if (i < log_n) begin
      check(log_wr[i] == wr && log_addr[i] == a, {tag, " access kind/address"},
            {log_wr[i], log_addr[i]}, {wr, a});
      if (wr) check(log_data[i] == d, {tag, " write data"}, log_data[i], d);
    end
    i++;
  endtask

  task automatic check_normal(input bit peri_wr, input int polls, input int d0);
    int i, c_cfg, c_poll, c_sw;
    i = 0;
    exp_acc(i, 1'b0, A_PERI, 0, "R2 peri read");
    if (peri_wr) exp_acc(i, 1'b1, A_PERI, 32'h8004_1811, "R2 peri rewrite");
    c_cfg = i;
    exp_acc(i, 1'b1, A_CFG, 32'h0001_0203, "R3 osc/divider config");
    exp_acc(i, 1'b1, A_PLL, 32'h0000_1010, "R4 factor write, enable clear");
    if (i <= log_n)
      check(log_cyc[i-1] - log_cyc[c_cfg] >= OSC_N*P && log_cyc[i-1] - log_cyc[c_cfg] <= OSC_N*P+8,
            "R4 osc settle gap", log_cyc[i-1] - log_cyc[c_cfg], OSC_N*P);
    exp_acc(i, 1'b0, A_PLL, 0, "R5 pll read");
    exp_acc(i, 1'b1, A_PLL, 32'h8000_1010, "R5 enable rmw");
    for (int k = 0; k <= polls; k++) exp_acc(i, 1'b0, A_PLL, 0, "R6 lock poll");
    c_poll = i - 1;
    exp_acc(i, 1'b0, A_CFG, 0, "R6 config read");
    if (i <= log_n && c_poll >= 0)
      check(log_cyc[i-1] - log_cyc[c_poll] >= LOCK_N*P && log_cyc[i-1] - log_cyc[c_poll] <= LOCK_N*P+8,
            "R6 lock settle gap", log_cyc[i-1] - log_cyc[c_poll], LOCK_N*P);
    c_sw = i;
    exp_acc(i, 1'b1, A_CFG, 32'h0002_0203, "R6 source back to pll");
    check(log_n == i, "R7 no access after switch", log_n, i);
    check(done_cnt == d0 + 1, "R7 single done pulse", done_cnt, d0 + 1);
    if (c_sw < log_n)
      check(done_cyc - log_cyc[c_sw] >= SW_N*P && done_cyc - log_cyc[c_sw] <= SW_N*P+8,
            "R7 switch settle gap", done_cyc - log_cyc[c_sw], SW_N*P);
    check(!busy && !error, "R7 idle without error", {busy, error}, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !error && !bus_valid, "R1 reset outputs",
          {busy, done, error, bus_valid}, 0);
  endtask

  task automatic t_normal_rewrite();
    int d0;
    d0 = done_cnt;
    prep(32'h0001_2345, 2, 0);
    pulse_start();
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    wait_idle(20000);
    repeat (20) @(negedge clk);
    check_normal(1'b1, 2, d0);
  endtask

  task automatic t_normal_skip();
    int d0;
    d0 = done_cnt;
    prep(32'h7004_1811, 0, 2);
    pulse_start();
    wait_idle(20000);
    repeat (20) @(negedge clk);
    check_normal(1'b0, 0, d0);
  endtask

  task automatic t_timeout();
    int d0, n0, c_en;
    d0 = done_cnt;
    prep(32'h8004_1811, 100000, 0);
    lock_timeout_us = 16'd3;
    pulse_start();
    wait_idle(20000);
    check(error == 1'b1 && busy == 1'b0, "R8 error raised", {error, busy}, 2'b10);
    c_en = 4;
    if (log_n > c_en)
      check(log_wr[c_en] && err_cyc - log_cyc[c_en] >= 3*P && err_cyc - log_cyc[c_en] <= 3*P+14,
            "R8 timeout window", err_cyc - log_cyc[c_en], 3*P);
    n0 = log_n;
    repeat (60) @(negedge clk);
    check(log_n == n0, "R8 no access after error", log_n, n0);
    check(log_n > 0 && log_addr[log_n-1] == A_PLL && !log_wr[log_n-1], "R8 last access is poll",
          log_addr[log_n-1], A_PLL);
    check(cfg_reg[17:16] == 2'd1, "R8 cpu left on crystal", cfg_reg[17:16], 1);
    check(done_cnt == d0, "R8 no done", done_cnt, d0);
    lock_timeout_us = 16'd500;
  endtask

  task automatic t_restart_clears();
    int d0;
    d0 = done_cnt;
    prep(32'h0000_0000, 1, 1);
    pulse_start();
    check(error == 1'b0, "R8 error cleared by start", error, 0);
    wait_idle(20000);
    repeat (20) @(negedge clk);
    check_normal(1'b1, 1, d0);
  endtask

  task automatic t_start_busy();
    int d0;
    d0 = done_cnt;
    prep(32'h8004_1811, 1, 0);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (200) @(negedge clk);
    pulse_start();
    wait_idle(20000);
    repeat (20) @(negedge clk);
    check(log_n == 9, "R9 start while busy ignored, access count", log_n, 9);
    check_normal(1'b0, 1, d0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal_rewrite();
    t_normal_skip();
    t_timeout();
    t_restart_clears();
    t_start_busy();
    finish_run();
  end
endmodule